// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags

This block computes one of four operations (addition, bitwise AND, OR, XOR) on two N-bit operands and keeps a registered set of four condition flags: carry, signed overflow, zero and even parity. An operation is accepted on any clock edge where the valid strobe is high. The result and the flags it produces appear on the outputs after that edge and hold until the next accepted operation.

Flags are updated selectively. Addition writes all four. The three logical operations write only zero and parity, so a carry or overflow left by an earlier addition survives any number of logical operations.

A branch-condition evaluator reads the registered flags. A three-bit selector picks one flag, either as it is or inverted, and the evaluator drives a taken signal from that flag alone. Evaluating a condition is purely combinational and never writes the flags.

Top module: `alu_flags_unit`

## Requirements
- R1: With op_code 0 (add), result becomes (opnd_a + opnd_b) mod 2^W and flag_c becomes the carry out of the most significant bit.
- R2: On an add, flag_v becomes the XOR of the carry into the most significant bit and the carry out of it. This is the same as: both operands have the same sign and the result has the other sign.
- R3: With op_code 1 (AND), 2 (OR) or 3 (XOR), result becomes the bitwise function of the operands, and flag_c and flag_v keep their previous values, whether those values are 0 or 1.
- R4: After every accepted operation, flag_z is 1 exactly when the result is all zeros.
- R5: After every accepted operation, flag_p is 1 exactly when the result holds an even number of one bits.
- R6: On a clock edge where op_valid is low, result and all four flags are unchanged.
- R7: A synchronous active-high reset clears result and all four flags to 0.
- R8: branch_taken follows cond_sel as follows: 0 gives flag_c, 1 gives flag_v, 2 gives flag_z and 3 gives flag_p; 4 to 7 give the inverse of the same flags in the same order. The output depends on no other flag.
- R9: Changing cond_sel, whether the branch is taken or not, leaves result and all flags unchanged.
- R10: All-ones plus zero gives an all-ones result with flag_c 0. All-ones plus one gives a zero result with flag_c 1 and flag_z 1.
- R11: Additions can set all four carry/overflow combinations (00, 01, 10, 11), and each combination is held through later logical operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operation on this edge |
| op_code | input | 2 | 0 add, 1 AND, 2 OR, 3 XOR |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| cond_sel | input | 3 | Branch condition selector (see R8) |
| result | output | W | Registered result of the last accepted operation |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Even-parity flag |
| branch_taken | output | 1 | Selected condition is true |

## Verification
The bench drives additions at the edges where a flag changes:
- 0x7FFF+1 and 0x8000+0x8000 reach overflow with and without carry. A design that takes overflow from the carry out alone, or that ties overflow to carry, reports the wrong pair at one of these points.
- The all-ones boundary sums catch a carry chain that is one bit short. Such a design fails to wrap to zero or to raise carry.

Each carry/overflow pair is then followed by logical operations, which exposes a unit that clears or recomputes those flags on AND/OR/XOR.

In each flag state the bench sweeps all eight selectors, then rereads the flags. This catches a selector wired to the wrong flag, a missing inversion, and any write-back caused by evaluating a branch.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_C = 2'd0,
        PICK_V = 2'd1,
        PICK_Z = 2'd2,
        PICK_P = 2'd3
    } flag_pick_e;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
        logic par;
    } flag_s;

    // Operations that must not disturb carry/overflow
    function automatic logic keeps_cv(alu_op_e op);
        return op != OP_ADD;
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           c_out,
    output logic           v_out
);
    localparam int LOW = W - 1;

    // Lower bits summed separately so the carry into the MSB is visible
    logic [LOW:0] low_sum;
    logic [1:0]   top_sum;

    always_comb begin
        low_sum = {1'b0, a[LOW-1:0]} + {1'b0, b[LOW-1:0]};
        top_sum = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, low_sum[LOW]};
        c_out   = top_sum[1];
        v_out   = top_sum[1] ^ low_sum[LOW];
        case (op)
            OP_ADD:  res = {top_sum[0], low_sum[LOW-1:0]};
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic         hold_cv,
    input  logic [W-1:0] res_in,
    input  logic         c_in,
    input  logic         v_in,
    output logic [W-1:0] res_q,
    output flag_s        flags_q
);
    flag_s nxt;

    always_comb begin
        nxt.zero  = ~|res_in;
        nxt.par   = ~^res_in;
        nxt.carry = hold_cv ? flags_q.carry : c_in;
        nxt.ovf   = hold_cv ? flags_q.ovf   : v_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (upd) begin
            res_q   <= res_in;
            flags_q <= nxt;
        end
    end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_flag_pkg::*;
(
    input  flag_s       flags,
    input  logic [2:0]  sel,
    output logic        taken
);
    logic picked;

    always_comb begin
        case (flag_pick_e'(sel[1:0]))
            PICK_C:  picked = flags.carry;
            PICK_V:  picked = flags.ovf;
            PICK_Z:  picked = flags.zero;
            PICK_P:  picked = flags.par;
            default: picked = 1'b0;
        endcase
        taken = picked ^ sel[2];
    end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [1:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   cond_sel,
    output logic [W-1:0] result,
    output logic         flag_c,
    output logic         flag_v,
    output logic         flag_z,
    output logic         flag_p,
    output logic         branch_taken
);
    alu_op_e      op;
    logic [W-1:0] core_res;
    logic         core_c;
    logic         core_v;
    flag_s        flags;

    assign op = alu_op_e'(op_code);

    alu_core #(.W(W)) u_core (
        .op    (op),
        .a     (opnd_a),
        .b     (opnd_b),
        .res   (core_res),
        .c_out (core_c),
        .v_out (core_v)
    );

    flag_reg #(.W(W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .upd     (op_valid),
        .hold_cv (keeps_cv(op)),
        .res_in  (core_res),
        .c_in    (core_c),
        .v_in    (core_v),
        .res_q   (result),
        .flags_q (flags)
    );

    branch_eval u_branch (
        .flags (flags),
        .sel   (cond_sel),
        .taken (branch_taken)
    );

    assign flag_c = flags.carry;
    assign flag_v = flags.ovf;
    assign flag_z = flags.zero;
    assign flag_p = flags.par;
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [1:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [2:0]   cond_sel,
    input logic [W-1:0] result,
    input logic         flag_c,
    input logic         flag_v,
    input logic         flag_z,
    input logic         flag_p,
    input logic         branch_taken
);
    logic [3:0] fvec;
    assign fvec = {flag_p, flag_z, flag_v, flag_c};

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=>
        ({flag_c, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    // R2
    add_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=>
        (flag_v == (($past(opnd_a[W-1]) == $past(opnd_b[W-1])) &&
                    (result[W-1] != $past(opnd_a[W-1])))));

    // R3
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code != 2'd0) |=> ($stable(flag_c) && $stable(flag_v)));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flag_z == (result == '0)));

    // R5
    parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flag_p == ($countones(result) % 2 == 0)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(result) && $stable(fvec)));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (result == '0 && fvec == 4'b0000));

    // R8
    branch_pick_chk: assert property (@(posedge clk) disable iff (rst)
        branch_taken == (fvec[cond_sel[1:0]] ^ cond_sel[2]));
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.W(W)) u_chk (.*);

// File: tb/alu_flags_unit_test.sv
module alu_flags_unit_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'd0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [2:0]   cond_sel = 3'd0;
    logic [W-1:0] result;
    logic         flag_c, flag_v, flag_z, flag_p, branch_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [W-1:0] e_r;
    logic e_c, e_v, e_z, e_p;

    alu_flags_unit #(.W(W)) uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .result(result), .flag_c(flag_c), .flag_v(flag_v),
        .flag_z(flag_z), .flag_p(flag_p), .branch_taken(branch_taken)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "result", result, e_r);
        check(req, "carry",  W'(flag_c), W'(e_c));
        check(req, "ovf",    W'(flag_v), W'(e_v));
        check(req, "zero",   W'(flag_z), W'(e_z));
        check(req, "parity", W'(flag_p), W'(e_p));
    endtask

    // Expected values from the requirements; applies one op and compares
    task automatic do_op(string req, logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] wide;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; op_valid = 1'b1;
        case (op)
            2'd0: begin
                wide = {1'b0, a} + {1'b0, b};
                e_r  = wide[W-1:0];
                e_c  = wide[W];
                e_v  = (a[W-1] == b[W-1]) && (e_r[W-1] != a[W-1]);
            end
            2'd1: e_r = a & b;
            2'd2: e_r = a | b;
            default: e_r = a ^ b;
        endcase
        e_z = (e_r == '0);
        e_p = ($countones(e_r) % 2 == 0);
        @(negedge clk);
        op_valid = 1'b0;
        check_all(req);
    endtask

    // R8 and R9: sweep every selector, then confirm the state is untouched
    task automatic test_branch_sweep();
        logic [3:0] fv;
        fv = {e_p, e_z, e_v, e_c};
        for (int s = 0; s < 8; s++) begin
            cond_sel = 3'(s);
            #2;
            check("R8", $sformatf("taken sel=%0d", s), W'(branch_taken),
                  W'(fv[s % 4] ^ (s >= 4)));
            @(negedge clk);
        end
        check_all("R9");
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e_r = '0; e_c = 0; e_v = 0; e_z = 0; e_p = 0;
        check_all("R7");
    endtask

    task automatic test_add_basic();
        do_op("R1", 2'd0, 16'h0001, 16'h0001);
        do_op("R1", 2'd0, 16'h1234, 16'h4321);
        do_op("R5", 2'd0, 16'h0001, 16'h0002);
    endtask

    task automatic test_boundary();
        do_op("R10", 2'd0, 16'hFFFF, 16'h0000);
        do_op("R10", 2'd0, 16'hFFFF, 16'h0001);
        test_branch_sweep();
    endtask

    task automatic test_cv_combos();
        do_op("R2", 2'd0, 16'h7FFF, 16'h0001);   // v=1 c=0
        test_branch_sweep();
        do_op("R11", 2'd1, 16'hF0F0, 16'h0FF0);
        do_op("R2", 2'd0, 16'h8000, 16'h8000);   // v=1 c=1
        test_branch_sweep();
        do_op("R11", 2'd2, 16'h0000, 16'h0000);
        do_op("R2", 2'd0, 16'hC000, 16'h4000);   // v=0 c=1
        do_op("R11", 2'd3, 16'h5555, 16'h5555);
        test_branch_sweep();
        do_op("R1", 2'd0, 16'h0003, 16'h0004);   // v=0 c=0
        do_op("R11", 2'd2, 16'hA5A5, 16'h0101);
        test_branch_sweep();
    endtask

    task automatic test_logic_ops();
        do_op("R3", 2'd0, 16'h8000, 16'h8000);
        do_op("R3", 2'd1, 16'hFFFF, 16'h00FF);
        do_op("R3", 2'd3, 16'hFFFF, 16'h00FF);
        do_op("R4", 2'd1, 16'hAAAA, 16'h5555);
        do_op("R3", 2'd2, 16'h0F00, 16'h00F1);
    endtask

    task automatic test_valid_gate();
        @(negedge clk);
        op_code = 2'd0; opnd_a = 16'h7FFF; opnd_b = 16'h7FFF; op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R6");
        op_code = 2'd3; opnd_a = 16'h1111;
        @(negedge clk);
        check_all("R6");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_branch_sweep();
        test_add_basic();
        test_boundary();
        test_cv_combos();
        test_logic_ops();
        test_valid_gate();
        test_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule